// File: doc/BRIEF.md
# Tag-Tracked Out-of-Order Issue Core

This block accepts instructions in program order and lets them execute out of order. Each instruction takes one of a small pool of waiting slots and one entry of a circular completion buffer. Every architectural register records either that it holds its current value or which buffer entry will produce that value. A waiting slot gathers both of its source operands and then hands the operation to an external functional unit. The unit returns results in any order through a result port. An accepted result is broadcast for one cycle on an internal result bus. Waiting slots that need that value pick it up from the bus, and the buffer entry stores it.

Results leave the buffer at its oldest end, strictly in issue order. Each one is written into its destination register. The register becomes valid again only if no younger instruction has claimed it since. The retire port shows every result as it leaves, so the order of retirement can be observed.

All three streams follow valid/ready rules. An instruction or a dispatch transfers on a clock edge where both valid and ready are high. A dispatch offer is held until it transfers. The result port is always ready, so every result offered is accepted in the cycle it is offered. The retire port has no ready and cannot be stalled.

Top module: `tagged_issue_core`

## Requirements
- R1: After reset, issue_ready is 1, disp_valid is 0 and ret_valid is 0, and architectural register i is valid and holds the value i.
- R2: issue_ready is 1 only when a waiting slot is free and the completion buffer is not full. With slots NRS and dispatch held off, issue_ready falls after NRS accepted instructions.
- R3: Each source operand of an issuing instruction is taken, in this order of preference, from the register if it is valid, else from the result bus if the bus carries the register's producer tag, else from the producing buffer entry if that entry has its result. Otherwise the slot waits on the producer tag.
- R4: An issuing instruction with issue_has_dst=1 makes its register not valid and names its own buffer entry as producer. A later reader therefore receives the value of the youngest earlier writer in program order.
- R5: disp_valid is 1 when an occupied slot has both operands ready. The lowest-numbered such slot is offered, with its op, operands and buffer tag. A slot is freed on the edge where disp_valid and disp_ready are both 1. An offer not taken stays offered.
- R6: res_ready is always 1. A result accepted with tag t appears on the internal result bus in the next cycle, and buffer entry t then holds it. res_tag must name a dispatched entry whose result has not yet been returned.
- R7: A waiting slot whose pending operand tag matches the result bus captures the bus data and becomes ready in the next cycle.
- R8: Results retire one per cycle, in issue order. ret_valid pulses with ret_has_dst, ret_dst and ret_data of the oldest entry once its result is stored. The register named by ret_dst takes ret_data.
- R9: At retirement, the destination register becomes valid only if its producer tag still names the retiring entry. A register claimed by a younger writer stays pending for that writer.
- R10: The buffer holds ROB_DEPTH entries. Tags are given in order from 0 after reset and wrap modulo ROB_DEPTH (a power of two). Head and tail pointers each carry an extra wrap bit to tell full from empty, so exactly ROB_DEPTH instructions can be in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Slot and buffer entry available |
| issue_op | input | OPW | Operation code, passed through to dispatch |
| issue_src_a | input | log2(NREG) | First source register |
| issue_src_b | input | log2(NREG) | Second source register |
| issue_has_dst | input | 1 | Instruction writes a register |
| issue_dst | input | log2(NREG) | Destination register |
| disp_valid | output | 1 | A ready slot is offered to the unit |
| disp_ready | input | 1 | Functional unit not stalled |
| disp_op | output | OPW | Operation of the offered slot |
| disp_a | output | DW | First operand value |
| disp_b | output | DW | Second operand value |
| disp_tag | output | log2(ROB_DEPTH) | Buffer entry of the offered instruction |
| res_valid | input | 1 | Result offered by the unit |
| res_ready | output | 1 | Result accepted (always 1) |
| res_tag | input | log2(ROB_DEPTH) | Buffer entry the result belongs to |
| res_data | input | DW | Result value |
| ret_valid | output | 1 | Oldest entry retires this cycle |
| ret_has_dst | output | 1 | Retiring entry writes a register |
| ret_dst | output | log2(NREG) | Register written by the retiring entry |
| ret_data | output | DW | Value retired |

## Verification
A wrong producer tag, a missed bus capture or a wrong choice of operand source shows up as a wrong disp_a or disp_b. This appears the first time the affected slot is offered, usually within a few cycles of the result it should have used. A retirement that wrongly marks a register valid is caught by the next reader of that register. That reader is offered a stale operand instead of waiting for the younger writer. Broken pointer wrap or full/empty logic shows as issue_ready at the wrong fill level, as a retire stream out of issue order, or as a dispatch tag that names no in-flight instruction.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_BYPASS  = 2'd1,
    SRC_ROBENT  = 2'd2,
    SRC_PENDING = 2'd3
  } opnd_src_e;

  // preference order: register, live result bus, stored buffer result
  function automatic opnd_src_e pick_source(input logic reg_ok, input logic bus_hit,
                                            input logic rob_ok);
    if (reg_ok)       return SRC_REGFILE;
    else if (bus_hit) return SRC_BYPASS;
    else if (rob_ok)  return SRC_ROBENT;
    else              return SRC_PENDING;
  endfunction
endpackage

// File: rtl/itc_regtab.sv
module itc_regtab #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ra_addr,
  output logic          ra_valid,
  output logic [TW-1:0] ra_tag,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_addr,
  output logic          rb_valid,
  output logic [TW-1:0] rb_tag,
  output logic [DW-1:0] rb_data,
  input  logic          iss_we,
  input  logic [RW-1:0] iss_addr,
  input  logic [TW-1:0] iss_tag,
  input  logic          ret_we,
  input  logic [RW-1:0] ret_addr,
  input  logic [TW-1:0] ret_tag,
  input  logic [DW-1:0] ret_data
);
  logic [DW-1:0] data_q  [NREG];
  logic [TW-1:0] tag_q   [NREG];
  logic          valid_q [NREG];

  assign ra_valid = valid_q[ra_addr];
  assign ra_tag   = tag_q[ra_addr];
  assign ra_data  = data_q[ra_addr];
  assign rb_valid = valid_q[rb_addr];
  assign rb_tag   = tag_q[rb_addr];
  assign rb_data  = data_q[rb_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        data_q[i]  <= DW'(i);
        tag_q[i]   <= '0;
        valid_q[i] <= 1'b1;
      end
    end else begin
      if (ret_we) begin
        data_q[ret_addr] <= ret_data;
        if (tag_q[ret_addr] == ret_tag) valid_q[ret_addr] <= 1'b1;
      end
      // a same-cycle claim by a new writer overrides the retire update
      if (iss_we) begin
        tag_q[iss_addr]   <= iss_tag;
        valid_q[iss_addr] <= 1'b0;
      end
    end
  end

  // R9
  stale_retire_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we && (tag_q[ret_addr] != ret_tag) |=> !valid_q[$past(ret_addr)]);
endmodule

// File: rtl/itc_rob.sv
module itc_rob #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int RW    = 3,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          alloc_has_dst,
  input  logic [RW-1:0] alloc_dst,
  output logic [TW-1:0] tail_tag,
  output logic          full,
  input  logic          cdb_v,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data,
  input  logic [TW-1:0] qa_tag,
  output logic          qa_done,
  output logic [DW-1:0] qa_data,
  input  logic [TW-1:0] qb_tag,
  output logic          qb_done,
  output logic [DW-1:0] qb_data,
  output logic          ret_valid,
  output logic [TW-1:0] ret_tag,
  output logic          ret_has_dst,
  output logic [RW-1:0] ret_dst,
  output logic [DW-1:0] ret_data
);
  logic [TW:0]   head_q, tail_q;
  logic          done_q   [DEPTH];
  logic          hasd_q   [DEPTH];
  logic [RW-1:0] dst_q    [DEPTH];
  logic [DW-1:0] val_q    [DEPTH];
  logic          empty;

  assign empty    = (head_q == tail_q);
  assign full     = (head_q[TW-1:0] == tail_q[TW-1:0]) && (head_q[TW] != tail_q[TW]);
  assign tail_tag = tail_q[TW-1:0];
  assign ret_tag  = head_q[TW-1:0];

  assign qa_done = done_q[qa_tag];
  assign qa_data = val_q[qa_tag];
  assign qb_done = done_q[qb_tag];
  assign qb_data = val_q[qb_tag];

  assign ret_valid   = !empty && done_q[ret_tag];
  assign ret_has_dst = hasd_q[ret_tag];
  assign ret_dst     = dst_q[ret_tag];
  assign ret_data    = val_q[ret_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        done_q[i] <= 1'b0;
        hasd_q[i] <= 1'b0;
        dst_q[i]  <= '0;
        val_q[i]  <= '0;
      end
    end else begin
      if (alloc) begin
        done_q[tail_tag] <= 1'b0;
        hasd_q[tail_tag] <= alloc_has_dst;
        dst_q[tail_tag]  <= alloc_has_dst ? alloc_dst : '0;
        tail_q           <= tail_q + 1'b1;
      end
      if (cdb_v) begin
        done_q[cdb_tag] <= 1'b1;
        val_q[cdb_tag]  <= cdb_data;
      end
      if (ret_valid) head_q <= head_q + 1'b1;
    end
  end

  // R2
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  // R6
  single_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_v |-> !empty && !done_q[cdb_tag]);
endmodule

// File: rtl/itc_stations.sv
module itc_stations #(
  parameter int NRS = 4,
  parameter int DW  = 16,
  parameter int TW  = 3,
  parameter int OPW = 2,
  parameter int SW  = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [OPW-1:0] alloc_op,
  input  logic [TW-1:0]  alloc_tag,
  input  logic           a_rdy,
  input  logic [TW-1:0]  a_tag,
  input  logic [DW-1:0]  a_val,
  input  logic           b_rdy,
  input  logic [TW-1:0]  b_tag,
  input  logic [DW-1:0]  b_val,
  output logic           has_free,
  input  logic           cdb_v,
  input  logic [TW-1:0]  cdb_tag,
  input  logic [DW-1:0]  cdb_data,
  output logic           disp_valid,
  input  logic           disp_ready,
  output logic [OPW-1:0] disp_op,
  output logic [DW-1:0]  disp_a,
  output logic [DW-1:0]  disp_b,
  output logic [TW-1:0]  disp_tag
);
  typedef struct packed {
    logic           full;
    logic [OPW-1:0] op;
    logic [TW-1:0]  rob;
    logic           ar;
    logic [TW-1:0]  at;
    logic [DW-1:0]  av;
    logic           br;
    logic [TW-1:0]  bt;
    logic [DW-1:0]  bv;
  } slot_t;

  slot_t         slot_q [NRS];
  logic [SW-1:0] free_idx, pick_idx;

  always_comb begin
    has_free   = 1'b0;
    free_idx   = '0;
    disp_valid = 1'b0;
    pick_idx   = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!slot_q[i].full) begin
        has_free = 1'b1;
        free_idx = SW'(i);
      end
      if (slot_q[i].full && slot_q[i].ar && slot_q[i].br) begin
        disp_valid = 1'b1;
        pick_idx   = SW'(i);
      end
    end
  end

  assign disp_op  = slot_q[pick_idx].op;
  assign disp_a   = slot_q[pick_idx].av;
  assign disp_b   = slot_q[pick_idx].bv;
  assign disp_tag = slot_q[pick_idx].rob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (slot_q[i].full && cdb_v) begin
          if (!slot_q[i].ar && slot_q[i].at == cdb_tag) begin
            slot_q[i].ar <= 1'b1;
            slot_q[i].av <= cdb_data;
          end
          if (!slot_q[i].br && slot_q[i].bt == cdb_tag) begin
            slot_q[i].br <= 1'b1;
            slot_q[i].bv <= cdb_data;
          end
        end
        if (disp_valid && disp_ready && pick_idx == SW'(i)) slot_q[i].full <= 1'b0;
        if (alloc && free_idx == SW'(i))
          slot_q[i] <= '{full: 1'b1, op: alloc_op, rob: alloc_tag,
                         ar: a_rdy, at: a_tag, av: a_val,
                         br: b_rdy, bt: b_tag, bv: b_val};
      end
    end
  end

  // R2
  no_alloc_without_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> has_free);

  for (genvar g = 0; g < NRS; g++) begin : g_snoop
    // R7
    snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q[g].full && !slot_q[g].ar && cdb_v && (slot_q[g].at == cdb_tag)
      |=> slot_q[g].ar && (slot_q[g].av == $past(cdb_data)));
  end
endmodule

// File: rtl/tagged_issue_core.sv
module tagged_issue_core #(
  parameter int NREG      = 8,
  parameter int DW        = 16,
  parameter int NRS       = 4,
  parameter int ROB_DEPTH = 8,
  parameter int OPW       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         issue_valid,
  output logic                         issue_ready,
  input  logic [OPW-1:0]               issue_op,
  input  logic [$clog2(NREG)-1:0]      issue_src_a,
  input  logic [$clog2(NREG)-1:0]      issue_src_b,
  input  logic                         issue_has_dst,
  input  logic [$clog2(NREG)-1:0]      issue_dst,
  output logic                         disp_valid,
  input  logic                         disp_ready,
  output logic [OPW-1:0]               disp_op,
  output logic [DW-1:0]                disp_a,
  output logic [DW-1:0]                disp_b,
  output logic [$clog2(ROB_DEPTH)-1:0] disp_tag,
  input  logic                         res_valid,
  output logic                         res_ready,
  input  logic [$clog2(ROB_DEPTH)-1:0] res_tag,
  input  logic [DW-1:0]                res_data,
  output logic                         ret_valid,
  output logic                         ret_has_dst,
  output logic [$clog2(NREG)-1:0]      ret_dst,
  output logic [DW-1:0]                ret_data
);
  import itc_pkg::*;
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(ROB_DEPTH);

  logic          cdb_v_q;
  logic [TW-1:0] cdb_tag_q;
  logic [DW-1:0] cdb_data_q;
  logic          issue_fire, rob_full, st_free;
  logic [TW-1:0] tail_tag, ret_tag;

  logic          reg_ok  [2];
  logic [TW-1:0] reg_tag [2];
  logic [DW-1:0] reg_val [2];
  logic          rob_ok  [2];
  logic [DW-1:0] rob_val [2];
  logic          op_rdy  [2];
  logic [TW-1:0] op_tag  [2];
  logic [DW-1:0] op_val  [2];

  assign res_ready   = 1'b1;
  assign issue_ready = st_free && !rob_full;
  assign issue_fire  = issue_valid && issue_ready;

  // result bus: one registered broadcast per accepted result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdb_v_q    <= 1'b0;
      cdb_tag_q  <= '0;
      cdb_data_q <= '0;
    end else begin
      cdb_v_q <= res_valid;
      if (res_valid) begin
        cdb_tag_q  <= res_tag;
        cdb_data_q <= res_data;
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    opnd_src_e src;
    assign src = pick_source(reg_ok[k], cdb_v_q && (cdb_tag_q == reg_tag[k]), rob_ok[k]);
    always_comb begin
      op_rdy[k] = 1'b1;
      op_tag[k] = reg_tag[k];
      case (src)
        SRC_REGFILE: op_val[k] = reg_val[k];
        SRC_BYPASS:  op_val[k] = cdb_data_q;
        SRC_ROBENT:  op_val[k] = rob_val[k];
        default: begin
          op_val[k] = '0;
          op_rdy[k] = 1'b0;
        end
      endcase
    end
  end

  itc_regtab #(.NREG(NREG), .DW(DW), .TW(TW)) u_regtab (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(issue_src_a), .ra_valid(reg_ok[0]), .ra_tag(reg_tag[0]), .ra_data(reg_val[0]),
    .rb_addr(issue_src_b), .rb_valid(reg_ok[1]), .rb_tag(reg_tag[1]), .rb_data(reg_val[1]),
    .iss_we(issue_fire && issue_has_dst), .iss_addr(issue_dst), .iss_tag(tail_tag),
    .ret_we(ret_valid && ret_has_dst), .ret_addr(ret_dst), .ret_tag(ret_tag),
    .ret_data(ret_data)
  );

  itc_rob #(.DEPTH(ROB_DEPTH), .DW(DW), .RW(RW)) u_rob (
    .clk(clk), .rst_n(rst_n),
    .alloc(issue_fire), .alloc_has_dst(issue_has_dst), .alloc_dst(issue_dst),
    .tail_tag(tail_tag), .full(rob_full),
    .cdb_v(cdb_v_q), .cdb_tag(cdb_tag_q), .cdb_data(cdb_data_q),
    .qa_tag(reg_tag[0]), .qa_done(rob_ok[0]), .qa_data(rob_val[0]),
    .qb_tag(reg_tag[1]), .qb_done(rob_ok[1]), .qb_data(rob_val[1]),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_has_dst(ret_has_dst),
    .ret_dst(ret_dst), .ret_data(ret_data)
  );

  itc_stations #(.NRS(NRS), .DW(DW), .TW(TW), .OPW(OPW)) u_stations (
    .clk(clk), .rst_n(rst_n),
    .alloc(issue_fire), .alloc_op(issue_op), .alloc_tag(tail_tag),
    .a_rdy(op_rdy[0]), .a_tag(op_tag[0]), .a_val(op_val[0]),
    .b_rdy(op_rdy[1]), .b_tag(op_tag[1]), .b_val(op_val[1]),
    .has_free(st_free),
    .cdb_v(cdb_v_q), .cdb_tag(cdb_tag_q), .cdb_data(cdb_data_q),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
  );

  // R5
  offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid);
endmodule

// File: tb/tagged_issue_core_tb.sv
module tagged_issue_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8, DW = 16, NRS = 4, DEPTH = 8, OPW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 0, issue_ready, issue_has_dst = 0;
  logic [OPW-1:0] issue_op = '0;
  logic [2:0] issue_src_a = '0, issue_src_b = '0, issue_dst = '0;
  logic disp_valid, disp_ready = 0;
  logic [OPW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;
  logic [2:0] disp_tag;
  logic res_valid = 0, res_ready;
  logic [2:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic ret_valid, ret_has_dst;
  logic [2:0] ret_dst;
  logic [DW-1:0] ret_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tagged_issue_core #(.NREG(NREG), .DW(DW), .NRS(NRS), .ROB_DEPTH(DEPTH), .OPW(OPW)) u_dut (.*);

  int total = 0, bad = 0;
  int iss_cnt = 0, ret_cnt = 0, pend_n = 0;
  logic [DW-1:0] arch [NREG];
  logic [OPW-1:0] rec_op [DEPTH];
  logic [DW-1:0] rec_a [DEPTH], rec_b [DEPTH], rec_res [DEPTH];
  logic rec_hd [DEPTH], rec_live [DEPTH], rec_disp [DEPTH];
  logic [2:0] rec_dst [DEPTH];
  logic [2:0] pend [16];
  logic prev_offer_stuck = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fu(input logic [OPW-1:0] op, input logic [DW-1:0] a,
                                       input logic [DW-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a & b;
    endcase
  endfunction

  // one bench cycle: observe at negedge, decide inputs for the next edge
  task automatic step(input int p_iss, input int p_disp, input int p_res);
    @(negedge clk);
    if (ret_valid) begin
      int t = ret_cnt % DEPTH;
      // R8 in-order retirement, R9 results of overlapping writers
      chk(rec_live[t] && rec_disp[t], "R8 retire of live entry", ret_cnt, iss_cnt);
      chk(ret_has_dst == rec_hd[t], "R8 has_dst", ret_has_dst, rec_hd[t]);
      if (rec_hd[t]) chk(ret_dst == rec_dst[t], "R8 dst", ret_dst, rec_dst[t]);
      chk(ret_data == rec_res[t], "R9 retire data", ret_data, rec_res[t]);
      rec_live[t] = 0;
      ret_cnt++;
    end
    if (prev_offer_stuck) chk(disp_valid, "R5 offer held", disp_valid, 1);
    disp_ready = ($urandom_range(99, 0) < p_disp);
    prev_offer_stuck = disp_valid && !disp_ready;
    res_valid = 0;
    if (pend_n > 0 && $urandom_range(99, 0) < p_res) begin
      int k = $urandom_range(pend_n - 1, 0);
      res_valid = 1;
      res_tag = pend[k];
      res_data = rec_res[pend[k]];
      pend[k] = pend[pend_n - 1];
      pend_n--;
      chk(res_ready == 1'b1, "R6 result accepted", res_ready, 1);
    end
    if (disp_valid && disp_ready) begin
      chk(rec_live[disp_tag] && !rec_disp[disp_tag], "R10 dispatch tag in flight", disp_tag, 0);
      chk(disp_op == rec_op[disp_tag], "R5 op", disp_op, rec_op[disp_tag]);
      chk(disp_a == rec_a[disp_tag], "R3 R7 operand a", disp_a, rec_a[disp_tag]);
      chk(disp_b == rec_b[disp_tag], "R4 R1 operand b", disp_b, rec_b[disp_tag]);
      rec_disp[disp_tag] = 1;
      pend[pend_n] = disp_tag;
      pend_n++;
    end
    issue_valid   = ($urandom_range(99, 0) < p_iss);
    issue_op      = OPW'($urandom_range(3, 0));
    issue_src_a   = 3'($urandom_range(7, 0));
    issue_src_b   = 3'($urandom_range(7, 0));
    issue_has_dst = ($urandom_range(9, 0) != 0);
    issue_dst     = 3'($urandom_range(3, 0));
    if (issue_valid && issue_ready) begin
      int t = iss_cnt % DEPTH;
      rec_op[t] = issue_op;
      rec_a[t] = arch[issue_src_a];
      rec_b[t] = arch[issue_src_b];
      rec_res[t] = fu(issue_op, rec_a[t], rec_b[t]);
      rec_hd[t] = issue_has_dst;
      rec_dst[t] = issue_dst;
      rec_live[t] = 1;
      rec_disp[t] = 0;
      if (issue_has_dst) arch[issue_dst] = rec_res[t];
      iss_cnt++;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) arch[i] = DW'(i);
    for (int i = 0; i < DEPTH; i++) begin
      rec_live[i] = 0;
      rec_disp[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(issue_ready == 1, "R1 issue_ready", issue_ready, 1);
    chk(disp_valid == 0, "R1 disp_valid", disp_valid, 0);
    chk(ret_valid == 0, "R1 ret_valid", ret_valid, 0);

    // R2 slots fill when dispatch is held off
    repeat (8) step(100, 0, 0);
    @(negedge clk);
    chk(issue_ready == 0, "R2 slots full", issue_ready, 0);
    chk(iss_cnt == NRS, "R2 accepted count", iss_cnt, NRS);
    chk(disp_valid == 1, "R5 ready slot offered", disp_valid, 1);

    // R10 buffer fills to exactly DEPTH when results are withheld
    repeat (30) step(100, 100, 0);
    @(negedge clk);
    chk(issue_ready == 0, "R10 buffer full", issue_ready, 0);
    chk(iss_cnt - ret_cnt == DEPTH, "R10 in-flight count", iss_cnt - ret_cnt, DEPTH);

    // drain, then R8 everything retired
    repeat (60) step(0, 100, 100);
    chk(ret_cnt == iss_cnt, "R8 drained", ret_cnt, iss_cnt);

    // random phases with varying pressure
    repeat (3000) step(70, 60, 50);
    repeat (3000) step(90, 30, 80);
    repeat (3000) step(40, 90, 20);
    repeat (200) step(0, 100, 100);
    chk(ret_cnt == iss_cnt, "R8 final drain", ret_cnt, iss_cnt);
    chk(ret_cnt > 1000, "R6 throughput", ret_cnt, 1000);
    finish_run();
  end
endmodule